// File: doc/BRIEF.md
# HDLC Infrared Frame Transmitter

This block turns a stream of bytes into the 1.152 Mbps HDLC-style infrared frame. It reads the bytes from a byte FIFO, sends one line bit per clock and needs no gap between bits. A frame opens with one or more flag bytes. The payload follows, with a zero inserted after any run of five ones. If enabled, a 16-bit frame check sequence computed by the block comes next. A closing flag ends the frame. Shaping the line pulses is done elsewhere, on the serial output of this block.

The software that drives the FIFO marks the last byte of each message. It can also ask for extra leading flags, which give a slow transceiver or a slow interrupt path time to settle. In brick-wall mode the block sends the next queued frame straight after the current one, separated only by a programmed number of flags. When the FIFO runs dry before the marked byte arrives, the block aborts the frame and reports an underrun.

Top module: `hdlc_ir_tx`

## Requirements
- R1: During and after reset, and while no frame is being sent, ser_out, active_frame, eom, underrun and fifo_rd are all 0.
- R2: The flag is the byte 0x7E. Every byte goes onto ser_out least significant bit first, one bit per clock, with no idle cycle between bytes. A frame starts whenever the FIFO is not empty.
- R3: With brick-wall mode off, a frame starts with 1 + bof_cnt flags, where bof_cnt can be 0 to 4095.
- R4: After five consecutive 1s in the payload or the FCS, a 0 is inserted. Flags and abort bytes are never stuffed.
- R5: With crc_sel = 1, the ones complement of a CRC is appended after the last payload byte, low byte first, and the appended bytes are also stuffed. The CRC uses x^16+x^12+x^5+1, starts at 0xFFFF and takes each bit least significant first.
- R6: With crc_sel = 0, no FCS is appended. The bytes from the host, including any FCS the host supplies, are sent as they are.
- R7: A byte read with fifo_last = 1 is the last byte of the message. After it (and after the FCS, when one is appended) exactly one closing flag is sent.
- R8: eom is high for exactly one cycle, the cycle right after the last bit of a closing flag has been on ser_out.
- R9: If the FIFO is empty when the next payload byte is needed and no marked byte has been read, the block raises underrun for one cycle. It then sends eight 1s and ends the frame without eom.
- R10: With bw_en = 1, frames start with a single flag whatever bof_cnt holds. If the FIFO holds data when a closing flag ends, bw_cnt flags follow, then one opening flag, then the next frame. active_frame stays high across the gap.
- R11: active_frame is high exactly in the cycles where ser_out carries a frame bit.
- R12: fifo_rd pulses once for each byte taken and is never high while fifo_empty is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | FIFO has no byte to give |
| fifo_data | input | 8 | Byte at the head of the FIFO |
| fifo_last | input | 1 | Head byte ends the message |
| fifo_rd | output | 1 | Takes the head byte at this clock edge |
| crc_sel | input | 1 | 1: append the computed FCS |
| bof_cnt | input | 12 | Extra opening flags |
| bw_en | input | 1 | Brick-wall mode |
| bw_cnt | input | 12 | Gap flags between brick-walled frames |
| ser_out | output | 1 | Serial line bit |
| active_frame | output | 1 | ser_out carries a frame bit |
| eom | output | 1 | End-of-message pulse |
| underrun | output | 1 | Abort pulse after the FIFO ran dry |

## Verification
Some checks hold on every cycle and are made by assertions. The run of consecutive ones in the stuffer never passes five, and it is always zero while a flag or abort byte is shifted. No FIFO read happens while the FIFO is empty, the end-of-message and underrun pulses are one cycle wide and fall inside or just after a frame, and the line stays low outside a frame.

The rest is only visible in whole frames, so the bench's scenarios carry it. These scenarios compare the captured bit stream against a model built from the requirements. That comparison covers the exact flag counts with and without brick-wall mode, the stuffing positions, the FCS value and byte order, where eom falls in the stream, and the abort sequence.

// File: rtl/hdlc_ir_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_ir_tx_pkg;
    localparam int BYTE_W    = 8;
    localparam int FCS_W     = 16;
    localparam int STUFF_RUN = 5;
    localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
    localparam logic [BYTE_W-1:0] ABORT_BYTE = 8'hFF;
    localparam logic [FCS_W-1:0]  FCS_PRESET = 16'hFFFF;
    localparam logic [FCS_W-1:0]  FCS_POLY_R = 16'h8408;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FLAG, ST_DATA, ST_FCS_LO, ST_FCS_HI, ST_STOP, ST_ABORT
    } seq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
        logic              stuffable;
    } tx_byte_t;

    // One serial step of the reflected CRC register
    function automatic logic [FCS_W-1:0] fcs_bit_step(input logic [FCS_W-1:0] crc,
                                                      input logic b);
        fcs_bit_step = {1'b0, crc[FCS_W-1:1]} ^ (((crc[0] ^ b) == 1'b1) ? FCS_POLY_R : '0);
    endfunction
endpackage

// File: rtl/hdlc_fcs16.sv
`timescale 1ns/1ps
module hdlc_fcs16
    import hdlc_ir_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    input  logic             bit_i,
    output logic [FCS_W-1:0] fcs_next_o,
    output logic [FCS_W-1:0] fcs_q_o
);
    logic [FCS_W-1:0] fcs_q;

    always_comb fcs_next_o = adv ? fcs_bit_step(fcs_q, bit_i) : fcs_q;

    always_ff @(posedge clk) begin
        if (rst || clear) fcs_q <= FCS_PRESET;
        else              fcs_q <= fcs_next_o;
    end

    assign fcs_q_o = fcs_q;
endmodule

// File: rtl/hdlc_bit_shifter.sv
`timescale 1ns/1ps
module hdlc_bit_shifter
    import hdlc_ir_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     load,
    input  tx_byte_t load_byte,
    output logic     bit_o,
    output logic     adv_o,
    output logic     done_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  sent;
    logic [RUN_W-1:0]  ones, ones_nxt;
    logic              stuffable, stuff_now;

    always_comb begin
        stuff_now = stuffable && (ones == RUN_W'(STUFF_RUN));
        bit_o     = stuff_now ? 1'b0 : sh[0];
        adv_o     = en && !stuff_now;
        if (stuff_now)                  ones_nxt = '0;
        else if (stuffable && sh[0])    ones_nxt = ones + 1'b1;
        else                            ones_nxt = '0;
        if (stuff_now) done_o = en && (sent == CNT_W'(BYTE_W));
        else           done_o = en && (sent == CNT_W'(BYTE_W - 1)) &&
                                (ones_nxt != RUN_W'(STUFF_RUN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            sent      <= CNT_W'(BYTE_W);
            ones      <= '0;
            stuffable <= 1'b0;
        end else if (load) begin
            sh        <= load_byte.value;
            sent      <= '0;
            stuffable <= load_byte.stuffable;
            ones      <= load_byte.stuffable ? ones_nxt : '0;
        end else if (en) begin
            ones <= ones_nxt;
            if (!stuff_now && sent != CNT_W'(BYTE_W)) begin
                sh   <= {1'b0, sh[BYTE_W-1:1]};
                sent <= sent + 1'b1;
            end
        end
    end

    // R4
    run_limit_chk: assert property (@(posedge clk) disable iff (rst)
        ones <= RUN_W'(STUFF_RUN));
    // R4
    flag_nostuff_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !stuffable) |-> (ones == '0));
    // R2
    sent_range_chk: assert property (@(posedge clk) disable iff (rst)
        sent <= CNT_W'(BYTE_W));
endmodule

// File: rtl/hdlc_ir_tx.sv
`timescale 1ns/1ps
module hdlc_ir_tx
    import hdlc_ir_tx_pkg::*;
#(
    parameter int FLAG_CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fifo_empty,
    input  logic [7:0]            fifo_data,
    input  logic                  fifo_last,
    output logic                  fifo_rd,
    input  logic                  crc_sel,
    input  logic [FLAG_CNT_W-1:0] bof_cnt,
    input  logic                  bw_en,
    input  logic [FLAG_CNT_W-1:0] bw_cnt,
    output logic                  ser_out,
    output logic                  active_frame,
    output logic                  eom,
    output logic                  underrun
);
    seq_state_e            state_q, state_d;
    logic [FLAG_CNT_W-1:0] left_q, left_d;
    logic                  last_q, last_d;
    logic                  ld, eom_set, under_set, eom_pend;
    tx_byte_t              ld_byte;
    logic                  sh_bit, sh_adv, sh_done, sh_en;
    logic [FCS_W-1:0]      fcs_next, fcs_q;

    assign sh_en = (state_q != ST_IDLE);

    hdlc_bit_shifter u_shift (
        .clk(clk), .rst(rst), .en(sh_en), .load(ld), .load_byte(ld_byte),
        .bit_o(sh_bit), .adv_o(sh_adv), .done_o(sh_done)
    );

    hdlc_fcs16 u_fcs (
        .clk(clk), .rst(rst), .clear(state_q == ST_FLAG),
        .adv(sh_adv && state_q == ST_DATA), .bit_i(sh_bit),
        .fcs_next_o(fcs_next), .fcs_q_o(fcs_q)
    );

    always_comb begin
        state_d   = state_q;
        left_d    = left_q;
        last_d    = last_q;
        ld        = 1'b0;
        ld_byte   = '{value: FLAG_BYTE, stuffable: 1'b0};
        fifo_rd   = 1'b0;
        eom_set   = 1'b0;
        under_set = 1'b0;
        unique case (state_q)
            ST_IDLE: if (!fifo_empty) begin
                ld      = 1'b1;
                state_d = ST_FLAG;
                left_d  = bw_en ? '0 : bof_cnt;
            end
            ST_FLAG, ST_DATA: if (sh_done) begin
                ld = 1'b1;
                if (state_q == ST_FLAG && left_q != '0) begin
                    left_d = left_q - 1'b1;
                end else if (state_q == ST_DATA && last_q) begin
                    if (crc_sel) begin
                        ld_byte = '{value: ~fcs_next[BYTE_W-1:0], stuffable: 1'b1};
                        state_d = ST_FCS_LO;
                    end else begin
                        state_d = ST_STOP;
                    end
                end else if (fifo_empty) begin
                    ld_byte   = '{value: ABORT_BYTE, stuffable: 1'b0};
                    state_d   = ST_ABORT;
                    under_set = 1'b1;
                end else begin
                    fifo_rd = 1'b1;
                    ld_byte = '{value: fifo_data, stuffable: 1'b1};
                    last_d  = fifo_last;
                    state_d = ST_DATA;
                end
            end
            ST_FCS_LO: if (sh_done) begin
                ld      = 1'b1;
                ld_byte = '{value: ~fcs_q[FCS_W-1:BYTE_W], stuffable: 1'b1};
                state_d = ST_FCS_HI;
            end
            ST_FCS_HI: if (sh_done) begin
                ld      = 1'b1;
                state_d = ST_STOP;
            end
            ST_STOP: if (sh_done) begin
                eom_set = 1'b1;
                if (bw_en && !fifo_empty) begin
                    ld      = 1'b1;
                    state_d = ST_FLAG;
                    left_d  = bw_cnt;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ABORT: if (sh_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            left_q       <= '0;
            last_q       <= 1'b0;
            ser_out      <= 1'b0;
            active_frame <= 1'b0;
            eom_pend     <= 1'b0;
            eom          <= 1'b0;
            underrun     <= 1'b0;
        end else begin
            state_q      <= state_d;
            left_q       <= left_d;
            last_q       <= last_d;
            ser_out      <= sh_en && sh_bit;
            active_frame <= sh_en;
            eom_pend     <= eom_set;
            eom          <= eom_pend;
            underrun     <= under_set;
        end
    end

    // R12
    rd_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);
    // R8
    eom_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eom |=> !eom);
    // R8
    eom_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        eom |-> $past(active_frame));
    // R9
    under_inframe_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |-> (active_frame && !eom));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !active_frame |-> !ser_out);
endmodule

// File: tb/hdlc_ir_tx_bench.sv
`timescale 1ns/1ps
module hdlc_ir_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_empty, fifo_last, fifo_rd;
    logic [7:0]  fifo_data;
    logic        crc_sel = 1'b1, bw_en = 1'b0;
    logic [11:0] bof_cnt = '0, bw_cnt = '0;
    logic        ser_out, active_frame, eom, underrun;

    always #4 clk = ~clk;

    logic [7:0] q_d [0:63];
    logic       q_l [0:63];
    int head = 0, tail = 0, pops = 0;
    assign fifo_empty = (head == tail);
    assign fifo_data  = q_d[head[5:0]];
    assign fifo_last  = q_l[head[5:0]];

    hdlc_ir_tx u_hdlc_ir_tx (
        .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_last(fifo_last), .fifo_rd(fifo_rd), .crc_sel(crc_sel),
        .bof_cnt(bof_cnt), .bw_en(bw_en), .bw_cnt(bw_cnt), .ser_out(ser_out),
        .active_frame(active_frame), .eom(eom), .underrun(underrun)
    );

    int total = 0, fails = 0;
    logic cap [0:8191];
    logic exp_b [0:8191];
    int n = 0, en = 0, e_ones = 0, eom_cnt = 0, und_cnt = 0;
    int eom_pos [0:3];
    logic eom_act [0:3];
    logic [7:0] fr [0:15];
    logic [15:0] b_crc;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // FIFO model: the head byte is removed one half cycle after the edge that took it
    initial begin
        bit pend, np;
        pend = 1'b0;
        forever begin
            @(negedge clk);
            np = fifo_rd;
            if (pend) begin head++; pops++; end
            pend = np;
        end
    end

    // Stream monitor
    initial begin
        forever begin
            @(negedge clk);
            if (eom) begin
                if (eom_cnt < 4) begin eom_pos[eom_cnt] = n; eom_act[eom_cnt] = active_frame; end
                eom_cnt++;
            end
            if (underrun) und_cnt++;
            if (active_frame && n < 8192) begin cap[n] = ser_out; n++; end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    task automatic push_bit(input logic b);
        exp_b[en] = b; en++;
    endtask

    task automatic exp_flag();
        for (int i = 0; i < 8; i++) push_bit(((8'h7E >> i) & 8'h01) != 0);
        e_ones = 0;
    endtask

    task automatic exp_stuffed(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            push_bit(v[i]);
            if (v[i]) e_ones++; else e_ones = 0;
            if (e_ones == 5) begin push_bit(1'b0); e_ones = 0; end
        end
    endtask

    task automatic crc_feed(input logic [7:0] v);
        b_crc = b_crc ^ {8'h00, v};
        for (int i = 0; i < 8; i++)
            b_crc = b_crc[0] ? ((b_crc >> 1) ^ 16'h8408) : (b_crc >> 1);
    endtask

    task automatic clear_run();
        n = 0; en = 0; e_ones = 0; eom_cnt = 0; und_cnt = 0;
        pops = 0; head = 0; tail = 0;
    endtask

    // Push fr[0..nb-1] and add payload (and FCS) to the expected stream
    task automatic queue_frame(input int nb, input bit mark_last, input bit want_fcs);
        b_crc = 16'hFFFF;
        for (int i = 0; i < nb; i++) begin
            q_d[tail[5:0]] = fr[i];
            q_l[tail[5:0]] = mark_last && (i == nb - 1);
            tail++;
            exp_stuffed(fr[i]);
            crc_feed(fr[i]);
        end
        if (want_fcs) begin
            exp_stuffed(~b_crc[7:0]);
            exp_stuffed(~b_crc[15:8]);
        end
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!active_frame && t < 3000) begin @(negedge clk); t++; end
        while (active_frame && t < 30000) begin @(negedge clk); t++; end
        repeat (5) @(negedge clk);
    endtask

    task automatic check_stream(input string req);
        int bad;
        bad = -1;
        check(n == en, req, "stream length", n, en);
        for (int i = 0; i < en && i < n; i++)
            if (bad < 0 && cap[i] != exp_b[i]) bad = i;
        check(bad < 0, req, "first wrong bit index", bad, -1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(ser_out == 0 && active_frame == 0, "R1", "outputs in reset", {ser_out, active_frame}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(ser_out == 0, "R1", "ser_out idle", ser_out, 0);
        check(active_frame == 0, "R1", "active_frame idle", active_frame, 0);
        check(eom == 0 && underrun == 0, "R1", "eom/underrun idle", {eom, underrun}, 0);
        check(fifo_rd == 0, "R1", "fifo_rd idle", fifo_rd, 0);
    endtask

    task automatic t_basic();
        clear_run();
        crc_sel = 1'b1; bw_en = 1'b0; bof_cnt = 12'd2;
        fr[0] = 8'h12; fr[1] = 8'h34; fr[2] = 8'hA5;
        for (int i = 0; i < 3; i++) exp_flag();
        queue_frame(3, 1'b1, 1'b1);
        exp_flag();
        wait_done();
        check_stream("R2/R3/R5/R7/R11");
        check(eom_cnt == 1, "R8", "eom pulses", eom_cnt, 1);
        check(eom_pos[0] == n && eom_act[0] == 0, "R8", "eom position", eom_pos[0], n);
        check(pops == 3 && fifo_empty, "R12", "bytes taken", pops, 3);
    endtask

    task automatic t_no_crc();
        clear_run();
        crc_sel = 1'b0; bw_en = 1'b0; bof_cnt = 12'd0;
        fr[0] = 8'h55; fr[1] = 8'h3C; fr[2] = 8'hC3;
        exp_flag();
        queue_frame(3, 1'b1, 1'b0);
        exp_flag();
        wait_done();
        check_stream("R6/R3");
        check(eom_cnt == 1, "R6", "eom pulses", eom_cnt, 1);
    endtask

    task automatic t_stuffing();
        clear_run();
        crc_sel = 1'b1; bw_en = 1'b0; bof_cnt = 12'd0;
        fr[0] = 8'hFF; fr[1] = 8'h7E; fr[2] = 8'h1F; fr[3] = 8'hF8;
        exp_flag();
        queue_frame(4, 1'b1, 1'b1);
        exp_flag();
        wait_done();
        check_stream("R4");
    endtask

    task automatic t_brickwall();
        clear_run();
        crc_sel = 1'b1; bw_en = 1'b1; bof_cnt = 12'd3; bw_cnt = 12'd2;
        fr[0] = 8'hA1; fr[1] = 8'h0F;
        exp_flag();
        queue_frame(2, 1'b1, 1'b1);
        exp_flag();
        begin
            int mid;
            mid = en;
            exp_flag(); exp_flag(); exp_flag();
            fr[0] = 8'h3E; fr[1] = 8'hFC; fr[2] = 8'h77;
            queue_frame(3, 1'b1, 1'b1);
            exp_flag();
            wait_done();
            check_stream("R10");
            check(eom_cnt == 2, "R10", "eom pulses", eom_cnt, 2);
            check(eom_pos[0] == mid && eom_act[0] == 1, "R10", "first eom position", eom_pos[0], mid);
            check(eom_pos[1] == n, "R8", "second eom position", eom_pos[1], n);
        end
        bw_en = 1'b0; bw_cnt = 12'd0;
    endtask

    task automatic t_underrun();
        clear_run();
        crc_sel = 1'b1; bw_en = 1'b0; bof_cnt = 12'd1;
        fr[0] = 8'h21; fr[1] = 8'h43;
        exp_flag(); exp_flag();
        queue_frame(2, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) push_bit(1'b1);
        wait_done();
        check_stream("R9");
        check(und_cnt == 1, "R9", "underrun pulses", und_cnt, 1);
        check(eom_cnt == 0, "R9", "eom after abort", eom_cnt, 0);
        check(pops == 2, "R12", "bytes taken", pops, 2);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_no_crc();
        t_stuffing();
        t_brickwall();
        t_underrun();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule